// File: doc/BRIEF.md
# Indirect Sub-Addressed Control Register Bank

This block is the host-facing control register file of a network controller. A handful of directly addressed registers sit on a narrow host port: a read-only status register, a read-only diagnostic register, a sub-address register and a configuration register. A single data address is steered to one of eight internal registers by a 3-bit sub-address. The two low sub-address bits are one shared storage that is visible and writable through both the configuration register and the sub-address register. The top bit lives only in the sub-address register, and every configuration write clears it.

The configuration register also holds three control bits. The software reset bit holds the status, diagnostic and next-ID registers at their reset values until the host clears it again. The command chaining bit is brought out as an output. The transmit enable bit gates the transmit-enable and line pulse outputs. The pulse outputs are gated only when the backplane-mode bit in setup register 1 is clear.

Top module: `subaddr_regbank`

## Requirements
- R1: After hardware reset, the configuration register, the sub-address register, the diagnostic register and all banked slots read 0, and the status register reads 0x80.
- R2: At direct address 7, sub-address codes 0 to 6 reach seven independent 8-bit registers (tentative ID, node ID, setup 1, next ID, setup 2, bus control, DMA count) that each read back what was last written to them.
- R3: Sub-address bits 1:0 are one storage. A write to the configuration register (direct address 6) or to the sub-address register (direct address 2) sets them from data bits 1:0, and both registers return them in bits 1:0.
- R4: Any write to the configuration register clears sub-address bit 2. A write to the sub-address register loads bit 2 from data bit 2.
- R5: Sub-address register bits 7:3 always read 0, and writes to them have no effect.
- R6: While configuration bit 7 is 1, the status register reads 0x80, and the diagnostic and next-ID registers read 0. Their set inputs and host writes to next ID are ignored. The hold ends when bit 7 is written back to 0.
- R7: The software reset leaves the configuration register and the banked registers other than next ID unchanged.
- R8: Configuration bit 5 is transmit enable and resets to 0. While it is 0, the transmit-enable output stays 0. While it is 1, the output follows its request.
- R9: The two pulse outputs follow their requests when transmit enable is 1 or when setup 1 bit 0 (backplane mode) is 1. Otherwise they stay 0.
- R10: Configuration bit 6 drives the command chaining output and resets to 0.
- R11: Sub-address code 7 is reserved: writes to it are ignored and reads of it return 0.
- R12: Direct address 0 returns status and address 1 returns diagnostic; both ignore writes. Status and diagnostic bits are set by pulses on their set inputs. Unmapped addresses, and any cycle without both chip select and read, give read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe, captured at the clock edge |
| addr | input | 3 | Direct register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| statSet | input | 8 | Bits to set in the status register |
| diagSet | input | 8 | Bits to set in the diagnostic register |
| txReq | input | 1 | Transmit-enable request from the protocol engine |
| pulse1Req | input | 1 | Line pulse 1 request |
| pulse2Req | input | 1 | Line pulse 2 request |
| txEnOut | output | 1 | Gated transmit enable |
| pulse1Out | output | 1 | Gated line pulse 1 |
| pulse2Out | output | 1 | Gated line pulse 2 |
| chainEn | output | 1 | Command chaining enable |

## Verification
The bench builds the block with its default parameters: 8-bit data, a 3-bit sub-address and a status reset value of 0x80. With these values all eight banked slots are reachable, including the reserved top code, so the bench can show bit 2 being set through the sub-address register and then dropped by a configuration write. It can also show the next-ID slot being held and then released by the software reset while its neighbours keep their contents.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STAT,
    RD_DIAG,
    RD_SUB,
    RD_CFG,
    RD_BANK
  } rdSrc_e;

  typedef struct packed {
    logic   cfgWr;
    logic   subWr;
    logic   bankWr;
    rdSrc_e rdSrc;
  } strobes_t;

  localparam int SLOT_NEXT_ID = 3;
  localparam int SLOT_SETUP1  = 2;
  localparam int CFG_SRST_BIT = 7;
  localparam int CFG_CHAIN_BIT = 6;
  localparam int CFG_TXEN_BIT = 5;

endpackage

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int STAT_ADDR = 0,
  parameter int DIAG_ADDR = 1,
  parameter int SUB_ADDR  = 2,
  parameter int CFG_ADDR  = 6,
  parameter int DATA_ADDR = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output strobes_t          stb
);

  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_DIAG = ADDR_W'(DIAG_ADDR);
  localparam logic [ADDR_W-1:0] A_SUB  = ADDR_W'(SUB_ADDR);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_ADDR);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);

  logic wrAcc;
  logic rdAcc;

  assign wrAcc = cs && wr;
  assign rdAcc = cs && rd;

  always_comb begin
    stb.cfgWr  = wrAcc && (addr == A_CFG);
    stb.subWr  = wrAcc && (addr == A_SUB);
    stb.bankWr = wrAcc && (addr == A_DATA);
    stb.rdSrc  = RD_NONE;
    if (rdAcc) begin
      unique case (addr)
        A_STAT:  stb.rdSrc = RD_STAT;
        A_DIAG:  stb.rdSrc = RD_DIAG;
        A_SUB:   stb.rdSrc = RD_SUB;
        A_CFG:   stb.rdSrc = RD_CFG;
        A_DATA:  stb.rdSrc = RD_BANK;
        default: stb.rdSrc = RD_NONE;
      endcase
    end
  end

  // R12
  one_write_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.cfgWr, stb.subWr, stb.bankWr}));

  // R12
  idle_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cs && rd) |-> (stb.rdSrc == RD_NONE));

endmodule

// File: rtl/regbank_dp.sv
module regbank_dp
  import regbank_pkg::*;
#(
  parameter int         DATA_W     = 8,
  parameter int         SUB_W      = 3,
  parameter logic [7:0] STATUS_RST = 8'h80,
  parameter int         BP_BIT     = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] statSet,
  input  logic [DATA_W-1:0] diagSet,
  input  logic              txReq,
  input  logic              pulse1Req,
  input  logic              pulse2Req,
  output logic [DATA_W-1:0] rdata,
  output logic              txEnOut,
  output logic              pulse1Out,
  output logic              pulse2Out,
  output logic              chainEn
);

  localparam int NSLOT    = 1 << SUB_W;
  localparam int SHARED_W = SUB_W - 1;
  localparam int RSVD     = NSLOT - 1;
  localparam logic [DATA_W-1:0] STAT_INIT = DATA_W'(STATUS_RST);

  logic [DATA_W-1:SHARED_W] cfgUpper;
  logic [SHARED_W-1:0]      subLow;
  logic                     subTop;
  logic [SUB_W-1:0]         subSel;
  logic [DATA_W-1:0]        statusQ;
  logic [DATA_W-1:0]        diagQ;
  logic [DATA_W-1:0]        slotQ [NSLOT];
  logic                     softRstOn;
  logic                     txEnBit;
  logic                     backplane;

  assign subSel    = {subTop, subLow};
  assign softRstOn = cfgUpper[CFG_SRST_BIT];
  assign txEnBit   = cfgUpper[CFG_TXEN_BIT];
  assign chainEn   = cfgUpper[CFG_CHAIN_BIT];
  assign backplane = slotQ[SLOT_SETUP1][BP_BIT];

  // configuration upper bits: untouched by the software reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cfgUpper <= '0;
    else if (stb.cfgWr) cfgUpper <= wdata[DATA_W-1:SHARED_W];
  end

  // shared low sub-address bits, written from either register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       subLow <= '0;
    else if (stb.cfgWr || stb.subWr) subLow <= wdata[SHARED_W-1:0];
  end

  // top sub-address bit: config write clears it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          subTop <= 1'b0;
    else if (stb.cfgWr) subTop <= 1'b0;
    else if (stb.subWr) subTop <= wdata[SHARED_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          statusQ <= STAT_INIT;
    else if (softRstOn) statusQ <= STAT_INIT;
    else                statusQ <= statusQ | statSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          diagQ <= '0;
    else if (softRstOn) diagQ <= '0;
    else                diagQ <= diagQ | diagSet;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : gSlot
    logic slotWr;
    assign slotWr = stb.bankWr && (subSel == SUB_W'(g));
    if (g == RSVD) begin : gRsvd
      assign slotQ[g] = '0;
    end else if (g == SLOT_NEXT_ID) begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          slotQ[g] <= '0;
        else if (softRstOn) slotQ[g] <= '0;
        else if (slotWr)    slotQ[g] <= wdata;
      end
    end else begin : gPlain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       slotQ[g] <= '0;
        else if (slotWr) slotQ[g] <= wdata;
      end
    end
  end

  always_comb begin
    unique case (stb.rdSrc)
      RD_STAT: rdata = statusQ;
      RD_DIAG: rdata = diagQ;
      RD_SUB:  rdata = DATA_W'(subSel);
      RD_CFG:  rdata = {cfgUpper, subLow};
      RD_BANK: rdata = slotQ[subSel];
      default: rdata = '0;
    endcase
  end

  assign txEnOut   = txReq && txEnBit;
  assign pulse1Out = pulse1Req && (txEnBit || backplane);
  assign pulse2Out = pulse2Req && (txEnBit || backplane);

  // R4
  subtop_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.cfgWr |=> (subSel[SUB_W-1] == 1'b0));

  // R3
  shared_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.subWr |=> (subLow == $past(wdata[SHARED_W-1:0])));

  // R6
  softrst_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    softRstOn |=> (statusQ == STAT_INIT && diagQ == '0 && slotQ[SLOT_NEXT_ID] == '0));

  // R7
  cfg_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (softRstOn && !stb.cfgWr) |=> $stable(cfgUpper));

  // R11
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdSrc == RD_BANK && subSel == SUB_W'(RSVD)) |-> (rdata == '0));

  // R8
  txen_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdSrc == RD_CFG && !rdata[CFG_TXEN_BIT]) |-> !txEnOut);

endmodule

// File: rtl/subaddr_regbank.sv
module subaddr_regbank
  import regbank_pkg::*;
#(
  parameter int         DATA_W     = 8,
  parameter int         ADDR_W     = 3,
  parameter int         SUB_W      = 3,
  parameter logic [7:0] STATUS_RST = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] statSet,
  input  logic [DATA_W-1:0] diagSet,
  input  logic              txReq,
  input  logic              pulse1Req,
  input  logic              pulse2Req,
  output logic              txEnOut,
  output logic              pulse1Out,
  output logic              pulse2Out,
  output logic              chainEn
);

  strobes_t stb;

  regbank_ctrl #(
    .ADDR_W(ADDR_W)
  ) uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .cs   (cs),
    .rd   (rd),
    .wr   (wr),
    .addr (addr),
    .stb  (stb)
  );

  regbank_dp #(
    .DATA_W    (DATA_W),
    .SUB_W     (SUB_W),
    .STATUS_RST(STATUS_RST)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wdata    (wdata),
    .statSet  (statSet),
    .diagSet  (diagSet),
    .txReq    (txReq),
    .pulse1Req(pulse1Req),
    .pulse2Req(pulse2Req),
    .rdata    (rdata),
    .txEnOut  (txEnOut),
    .pulse1Out(pulse1Out),
    .pulse2Out(pulse2Out),
    .chainEn  (chainEn)
  );

endmodule

// File: tb/subaddr_regbank_test.sv
module subaddr_regbank_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [7:0] statSet = '0, diagSet = '0;
  logic       txReq = 1'b1, pulse1Req = 1'b1, pulse2Req = 1'b1;
  logic       txEnOut, pulse1Out, pulse2Out, chainEn;

  always #(CLK_PERIOD/2) clk = ~clk;

  subaddr_regbank uut (
    .clk(clk), .rstN(rstN), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .statSet(statSet), .diagSet(diagSet),
    .txReq(txReq), .pulse1Req(pulse1Req), .pulse2Req(pulse2Req),
    .txEnOut(txEnOut), .pulse1Out(pulse1Out), .pulse2Out(pulse2Out),
    .chainEn(chainEn)
  );

  typedef struct {
    logic        isOuts;
    logic [11:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  int    nChk = 0;
  int    nFail = 0;
  logic  chkRd = 1'b0;
  logic  chkOuts = 1'b0;

  // monitor: samples mid-cycle, away from the active edge
  always @(negedge clk) begin
    if (chkRd || chkOuts) begin
      item_t       it;
      logic [11:0] act;
      nChk++;
      if (sbq.size() == 0) begin
        nFail++;
        $display("FAIL scoreboard empty: actual rdata %02h expected an item", rdata);
      end else begin
        it  = sbq.pop_front();
        act = it.isOuts ? {rdata, txEnOut, pulse1Out, pulse2Out, chainEn}
                        : {rdata, 4'b0000};
        if (act !== it.exp) begin
          nFail++;
          $display("FAIL %s: actual %03h expected %03h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    cs = 1'b1; rd = 1'b1; addr = a; chkRd = 1'b1;
    it.isOuts = 1'b0; it.exp = {e, 4'b0000}; it.tag = tag;
    sbq.push_back(it);
    @(posedge clk); #1;
    cs = 1'b0; rd = 1'b0; chkRd = 1'b0;
  endtask

  // expected {txEnOut, pulse1Out, pulse2Out, chainEn} with no read active
  task automatic chkOut(input logic [3:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    chkOuts = 1'b1;
    it.isOuts = 1'b1; it.exp = {8'h00, e}; it.tag = tag;
    sbq.push_back(it);
    @(posedge clk); #1;
    chkOuts = 1'b0;
  endtask

  task automatic pulseSet(input logic [7:0] s, input logic [7:0] dg);
    @(posedge clk); #1;
    statSet = s; diagSet = dg;
    @(posedge clk); #1;
    statSet = '0; diagSet = '0;
  endtask

  task automatic finishRun();
    if (sbq.size() != 0) begin
      nFail++;
      $display("FAIL scoreboard leftover: actual %0d items expected 0", sbq.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset values
    rdReg(3'd6, 8'h00, "R1 config");
    rdReg(3'd2, 8'h00, "R1 subaddr");
    rdReg(3'd0, 8'h80, "R1 status");
    rdReg(3'd1, 8'h00, "R1 diag");
    rdReg(3'd7, 8'h00, "R1 slot0");
    chkOut(4'b0000, "R1 R8 R9 R10 outputs gated after reset");

    // R2 banked slots
    for (int i = 0; i < 7; i++) begin
      wrReg(3'd2, 8'(i));
      wrReg(3'd7, 8'(8'h10 + i));
    end
    for (int i = 0; i < 7; i++) begin
      wrReg(3'd2, 8'(i));
      rdReg(3'd7, 8'(8'h10 + i), "R2 slot readback");
    end

    // R5 upper subaddr bits
    wrReg(3'd2, 8'hFD);
    rdReg(3'd2, 8'h05, "R5 subaddr upper bits");

    // R3 R4 shared bits
    wrReg(3'd6, 8'h02);
    rdReg(3'd2, 8'h02, "R4 config write clears bit2");
    wrReg(3'd2, 8'h07);
    rdReg(3'd6, 8'h03, "R3 config shows subaddr bits");
    rdReg(3'd2, 8'h07, "R4 subaddr write sets bit2");

    // R11 reserved slot
    wrReg(3'd7, 8'hAA);
    rdReg(3'd7, 8'h00, "R11 reserved slot");
    wrReg(3'd2, 8'h06);
    rdReg(3'd7, 8'h16, "R11 neighbour intact");

    // R12 direct map and idle read data
    rdReg(3'd3, 8'h00, "R12 unmapped address");
    wrReg(3'd0, 8'h00);
    pulseSet(8'h01, 8'h04);
    rdReg(3'd0, 8'h81, "R12 status set");
    rdReg(3'd1, 8'h04, "R12 diag set");

    // R6 R7 software reset
    wrReg(3'd6, 8'h83);
    rdReg(3'd0, 8'h80, "R6 status held");
    rdReg(3'd1, 8'h00, "R6 diag held");
    rdReg(3'd7, 8'h00, "R6 next id held");
    wrReg(3'd7, 8'h55);
    pulseSet(8'h02, 8'h08);
    rdReg(3'd7, 8'h00, "R6 next id write ignored");
    rdReg(3'd1, 8'h00, "R6 diag set ignored");
    rdReg(3'd6, 8'h83, "R7 config kept");
    wrReg(3'd6, 8'h81);
    rdReg(3'd7, 8'h11, "R7 node id kept");
    wrReg(3'd6, 8'h03);
    pulseSet(8'h02, 8'h00);
    rdReg(3'd0, 8'h82, "R6 released status");
    rdReg(3'd7, 8'h00, "R6 next id after release");

    // R8 R9 R10 output gating
    wrReg(3'd6, 8'h20);
    chkOut(4'b1110, "R8 transmit enabled");
    wrReg(3'd6, 8'h40);
    chkOut(4'b0001, "R10 chain on, R8 tx gated, R9 pulses gated");
    wrReg(3'd2, 8'h02);
    wrReg(3'd7, 8'h13);
    wrReg(3'd6, 8'h42);
    chkOut(4'b0111, "R9 backplane passes pulses");
    txReq = 1'b0;
    wrReg(3'd6, 8'h22);
    chkOut(4'b0110, "R8 output follows request");

    finishRun();
  end

endmodule